// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned N-bit integer by another over several clock cycles. It uses the restoring shift-subtract method. A finite-state controller steers a datapath that holds a partial remainder, a shifting quotient register, the latched divisor and an iteration counter. The bench builds it with N = 8, which is also the default. A start input that behaves like a push button begins a division. The block then spends one cycle latching the operands and N cycles iterating. At the end it publishes the quotient and the remainder on registered outputs and raises a completion flag.

The start input is sensed by level. Once a result has been published, the controller ignores the start input until it has seen that input low. A button held down therefore yields exactly one division, and the result stays on the outputs until the button is released and pressed again. A zero divisor is caught while the operands are latched. In that case the block skips the iterations, raises the error flag together with the completion flag, and drives zero on both result outputs.

Top module: `restoring_divider`

## Requirements
- R1: For a nonzero divisor, the completed result shows quot_o = floor(dividend / divisor) and rem_o = dividend mod divisor, both read as unsigned WIDTH-bit values.
- R2: For a nonzero divisor, done_o rises on the WIDTH+2nd rising clock edge after the edge that accepts start_i: one accept edge, one load edge and WIDTH iteration edges. Once high, done_o stays high until a new start is accepted.
- R3: While start_i stays high after a result has been published, quot_o, rem_o, done_o and err_o hold their values and no new division begins.
- R4: After a result, a new division is accepted only once start_i has been sampled low and is then sampled high. The edge that accepts the new division clears done_o and err_o.
- R5: A zero divisor raises err_o and done_o together on the second edge after acceptance, with quot_o and rem_o both zero. Outside this case err_o stays low.
- R6: The dividend and divisor are sampled on the load edge, which is the edge after acceptance. Changes on them after that edge do not affect the result.
- R7: During a new computation, quot_o and rem_o keep the previous result. They change only on the edge that completes the division.
- R8: A synchronous active-high reset drives quot_o, rem_o, done_o and err_o to zero on the next edge. It also returns the controller to idle, where a high start_i is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Level-sensed start request (button) |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| quot_o | output | WIDTH | Registered quotient |
| rem_o | output | WIDTH | Registered remainder |
| done_o | output | 1 | Result valid |
| err_o | output | 1 | Division by zero detected |

## Verification
The bench builds the block with WIDTH = 8. At that width the full-scale corners can be reached directly: 255 divided by 1, 255 by 255, a zero dividend, and a divisor larger than the dividend. Many randomly timed presses also fit in a short run. The same width keeps the completion latency at ten edges. That makes it practical to release the button during the iterations, to hold it for long after completion, and to assert reset in the middle of a computation, all within a few cycles of each other.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_ITER  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_WREL  = 3'd4
   } div_state_t;
endpackage

// File: rtl/div_datapath.sv
module div_datapath #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic             step_en,
   input  logic             zero_en,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             b_zero_o,
   output logic             last_o,
   output logic [WIDTH-1:0] quot_o,
   output logic [WIDTH-1:0] rem_o
);
   localparam int CNT_W = $clog2(WIDTH);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

   logic [WIDTH-1:0] part_q, quo_q, dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic [WIDTH:0]   shifted, trial;
   logic             fits;
   logic [WIDTH-1:0] part_nx, quo_nx;

   // shift next dividend bit into partial remainder and try subtraction
   assign shifted  = {part_q, quo_q[WIDTH-1]};
   assign trial    = shifted - {1'b0, dvs_q};
   assign fits     = ~trial[WIDTH];
   assign part_nx  = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
   assign quo_nx   = {quo_q[WIDTH-2:0], fits};
   assign last_o   = (cnt_q == LAST_IDX);
   assign b_zero_o = (b_i == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         part_q <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         cnt_q  <= '0;
         quot_o <= '0;
         rem_o  <= '0;
      end else begin
         if (load_en) begin
            part_q <= '0;
            quo_q  <= a_i;
            dvs_q  <= b_i;
            cnt_q  <= '0;
         end
         if (step_en) begin
            part_q <= part_nx;
            quo_q  <= quo_nx;
            cnt_q  <= cnt_q + 1'b1;
            if (last_o) begin
               quot_o <= quo_nx;
               rem_o  <= part_nx;
            end
         end
         if (zero_en) begin
            quot_o <= '0;
            rem_o  <= '0;
         end
      end
   end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
   import div_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic b_zero_i,
   input  logic last_i,
   output logic load_en,
   output logic step_en,
   output logic zero_en,
   output logic done_o,
   output logic err_o
);
   div_state_t state_q, state_nx;
   logic       accept;

   assign accept  = ((state_q == ST_IDLE) || (state_q == ST_WREL)) && start_i;
   assign load_en = (state_q == ST_LOAD);
   assign step_en = (state_q == ST_ITER);
   assign zero_en = load_en && b_zero_i;

   always_comb begin
      state_nx = state_q;
      case (state_q)
         ST_IDLE, ST_WREL: if (start_i) state_nx = ST_LOAD;
         ST_LOAD:          state_nx = b_zero_i ? ST_HOLD : ST_ITER;
         ST_ITER:          if (last_i) state_nx = ST_HOLD;
         ST_HOLD:          if (!start_i) state_nx = ST_WREL;
         default:          state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (accept) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
         end else if (zero_en) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
         end else if (step_en && last_i) begin
            done_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic [WIDTH-1:0] quot_o,
   output logic [WIDTH-1:0] rem_o,
   output logic             done_o,
   output logic             err_o
);
   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("restoring_divider: WIDTH must be at least 2");
      end
   endgenerate

   logic load_en, step_en, zero_en, b_zero, last_step;

   div_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .b_zero_i (b_zero),
      .last_i   (last_step),
      .load_en  (load_en),
      .step_en  (step_en),
      .zero_en  (zero_en),
      .done_o   (done_o),
      .err_o    (err_o)
   );

   div_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en),
      .step_en  (step_en),
      .zero_en  (zero_en),
      .a_i      (dividend_i),
      .b_i      (divisor_i),
      .b_zero_o (b_zero),
      .last_o   (last_step),
      .quot_o   (quot_o),
      .rem_o    (rem_o)
   );
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [WIDTH-1:0] quot_o,
   input logic [WIDTH-1:0] rem_o,
   input logic             done_o,
   input logic             err_o
);
   // R3
   held_result_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && start_i && $past(start_i)) |=>
      (done_o && $stable(quot_o) && $stable(rem_o) && $stable(err_o)));

   // R4
   restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(done_o) && !$past(start_i) && done_o && start_i) |=> (!done_o && !err_o));

   // R5
   zero_div_out_chk: assert property (@(posedge clk) disable iff (rst)
      err_o |-> (done_o && quot_o == '0 && rem_o == '0));

   // R2
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (done_o && !start_i) |=> done_o);

   // R7
   result_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !done_o |=> (done_o || ($stable(quot_o) && $stable(rem_o))));
endmodule

bind restoring_divider restoring_divider_chk #(.WIDTH(WIDTH)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .quot_o  (quot_o),
   .rem_o   (rem_o),
   .done_o  (done_o),
   .err_o   (err_o)
);

// File: tb/restoring_divider_tb_top.sv
`timescale 1ns/1ps
module restoring_divider_tb_top;
   localparam int WIDTH = 8;
   localparam int MAXV  = (1 << WIDTH) - 1;

   logic             clk = 1'b0;
   logic             rst;
   logic             start;
   logic [WIDTH-1:0] a, b;
   logic [WIDTH-1:0] quot, rem;
   logic             done, err;

   int n_chk  = 0;
   int n_fail = 0;
   bit cmp_on = 0;
   int prev_q = 0, prev_r = 0;

   always #2 clk = ~clk;

   restoring_divider #(.WIDTH(WIDTH)) dut_i (
      .clk(clk), .rst(rst), .start_i(start), .dividend_i(a), .divisor_i(b),
      .quot_o(quot), .rem_o(rem), .done_o(done), .err_o(err)
   );

   // behavioural reference model, stepped on every rising edge
   int m_q, m_r, m_a, m_b, m_iter;
   bit m_done, m_err, m_load, m_hold;

   always @(posedge clk) begin
      if (rst) begin
         m_q = 0; m_r = 0; m_done = 0; m_err = 0;
         m_load = 0; m_iter = 0; m_hold = 0;
      end else if (m_load) begin
         m_load = 0; m_a = int'(a); m_b = int'(b);
         if (m_b == 0) begin
            m_q = 0; m_r = 0; m_err = 1; m_done = 1; m_hold = 1;
         end else m_iter = WIDTH;
      end else if (m_iter > 0) begin
         m_iter--;
         if (m_iter == 0) begin
            m_q = m_a / m_b; m_r = m_a % m_b; m_done = 1; m_hold = 1;
         end
      end else if (m_hold) begin
         if (!start) m_hold = 0;
      end else if (start) begin
         m_done = 0; m_err = 0; m_load = 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         check(int'(quot) == m_q, "R1 quotient vs model", int'(quot), m_q);
         check(int'(rem) == m_r, "R1 remainder vs model", int'(rem), m_r);
         check(done == m_done, "R2 done vs model", int'(done), int'(m_done));
         check(err == m_err, "R5 error vs model", int'(err), int'(m_err));
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // press and hold until done, then keep holding `hold` cycles, then release
   task automatic divide(input int ai, input int bi, input int hold, input bit glitch);
      int lat;
      int q0, r0;
      q0 = int'(quot); r0 = int'(rem);
      a = WIDTH'(ai); b = WIDTH'(bi); start = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (lat == 1) begin
            check(!done && !err, "R4 flags cleared on accept", int'(done), 0);
            check(int'(quot) == q0 && int'(rem) == r0, "R7 previous result kept",
                  int'(quot), q0);
         end
         if (glitch && lat == 2) begin
            a = WIDTH'($urandom); b = WIDTH'($urandom);
         end
      end while (!done && lat < 40);
      if (bi == 0) begin
         check(lat == 2, "R5 zero-divisor latency", lat, 2);
         check(err && quot == '0 && rem == '0, "R5 error with zero result", int'(err), 1);
      end else begin
         check(lat == WIDTH + 2, "R2 completion latency", lat, WIDTH + 2);
         check(int'(quot) == ai / bi, glitch ? "R6 quotient after operand change" : "R1 quotient",
               int'(quot), ai / bi);
         check(int'(rem) == ai % bi, glitch ? "R6 remainder after operand change" : "R1 remainder",
               int'(rem), ai % bi);
         check(!err, "R5 no error for nonzero divisor", int'(err), 0);
      end
      q0 = int'(quot); r0 = int'(rem);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (i == hold - 1)
            check(done && int'(quot) == q0 && int'(rem) == r0, "R3 result held with start high",
                  int'(quot), q0);
      end
      start = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      rst = 1'b1; start = 1'b0; a = '0; b = '0;
      repeat (3) @(negedge clk);
      check(quot == '0 && rem == '0 && !done && !err, "R8 reset state", int'(quot), 0);
      rst = 1'b0;
      cmp_on = 1;
      @(negedge clk);

      divide(200, 7, 3, 0);
      divide(MAXV, 1, 1, 0);
      divide(5, 9, 1, 0);
      divide(0, 3, 1, 0);
      divide(MAXV, MAXV, 30, 0);        // R3 long hold
      divide(77, 0, 4, 0);              // R5
      divide(128, 16, 1, 0);            // R4 clears error of previous
      divide(143, 11, 1, 1);            // R6 operands change mid-run

      // R4: held button across completion does not restart
      a = 8'd50; b = 8'd5; start = 1'b1;
      repeat (WIDTH + 12) @(negedge clk);
      check(done && int'(quot) == 10, "R4 no restart while held", int'(quot), 10);
      start = 1'b0;
      @(negedge clk);

      // R8: reset in the middle of a computation, then immediate accept
      a = 8'd99; b = 8'd4; start = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(quot == '0 && rem == '0 && !done && !err, "R8 reset mid-run", int'(quot), 0);
      rst = 1'b0;
      repeat (WIDTH + 2) @(negedge clk);
      check(done && int'(quot) == 24 && int'(rem) == 3, "R8 accepted right after reset",
            int'(quot), 24);
      start = 1'b0;
      @(negedge clk);

      // randomly timed presses, including release during the iterations
      for (int k = 0; k < 300; k++) begin
         int hold_c, low_c;
         a = WIDTH'($urandom);
         b = ($urandom_range(0, 15) == 0) ? '0 : WIDTH'($urandom);
         start = 1'b1;
         hold_c = $urandom_range(1, 14);
         repeat (hold_c) @(negedge clk);
         start = 1'b0;
         for (int w = 0; w < 20 && !done; w++) @(negedge clk);
         low_c = $urandom_range(1, 3);
         repeat (low_c) @(negedge clk);
      end

      report();
   end
endmodule